// File: doc/BRIEF.md
# Gated Front-End Control Register File

This block is the slave-side register bank of one front-end timing chip on a crate board. A host reaches it through a plain synchronous strobe port that stands in for the backplane bus. Each access carries a 32-bit longword address. That address must name this board through its slot code and must have its reserved bits clear. The bank holds the chip's configuration fields and drives them straight out as ports. These fields are the channel enable mask, the pipeline size, the buffer length, the clock-delay code, the bunch counter offset and three mode bits.

Configuration is protected by a test-mode switch. While the chip runs in operation mode, only two writes act. One is a write to the test-mode switch itself. The other is a write to the accept-trigger location, which may be written at any time. A write to the accept-trigger location fires a one-cycle accept pulse with a 2-bit code, but only when the accept source is set to the host. A clear location, active only in test mode, returns every configuration field to zero. Reads work in every mode and answer one cycle after the strobe.

Top module: `fe_ctrl_regs`

## Requirements
- R1: An access counts only if address bits [31:27] equal `geo_addr`, bits [26:24] are zero and bits [1:0] are zero. Any other write changes nothing, and any other read gives `rd_valid` = 0 with `rd_data` = 0.
- R2: Index 0x0F is write-only. Writing data bit 0 = 1 enters test mode and bit 0 = 0 returns to operation mode, whatever the current mode. Reset leaves the chip in operation mode. The mode is visible on `test_mode` one cycle after the write.
- R3: A write to any index other than 0x0F and 0x07 is ignored while test mode is off.
- R4: Index 0x07 takes a 2-bit code in data bits [1:0] in any mode. If the accept-source bit is 1, `accept_pulse` is high for exactly the cycle after the write and `accept_code` shows the code. If the accept-source bit is 0, no pulse is made and `accept_code` keeps its old value.
- R5: In test mode, a write to index 0x11 sets the mask, pipeline, length, delay, offset and the three mode bits to zero, and test mode stays on. In operation mode the same write has no effect.
- R6: Index 0 is read-only. It returns the 24-bit program tag in bits [31:8] and zero in bits [7:5]. Bits [4:0] hold, from bit 0 upward: chip ID, test-data mode, test mode, trigger flavour and accept source.
- R7: Index 3 holds the pipeline size in data bits [8:0] and the buffer length in bits [21:16]. All other bits read as zero.
- R8: Indices 1 and 2 hold bits [23:0] and [47:24] of the 48-bit channel mask in data bits [23:0], and the mask drives `wire_mask`. A 0 bit blocks its channel.
- R9: Index 8 holds the clock-delay code in bits [7:0] and the bunch offset in bits [15:8]. All other bits read as zero.
- R10: A read of an unmapped or write-only index returns zero with `rd_valid` = 1. Every read answers in the cycle after its strobe.
- R11: Indices 0x0B, 0x0C and 0x0D are write-only and set, from data bit 0, the accept source, the trigger flavour and the test-data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geo_addr | input | 5 | Board slot code |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 32 | Longword address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read answer for a matching address |
| wire_mask | output | 48 | Channel enable mask |
| pipe_size | output | 9 | Pipeline size |
| buf_len | output | 6 | Buffer length |
| clk_delay | output | 8 | Clock-delay code |
| bunch_offset | output | 8 | Bunch counter offset |
| test_mode | output | 1 | Test mode active |
| test_data_mode | output | 1 | Test-data source selected |
| flavor_new | output | 1 | New trigger flavour selected |
| accept_src_host | output | 1 | Accept source is the host |
| accept_pulse | output | 1 | One-cycle accept trigger |
| accept_code | output | 2 | Code of the last accepted trigger |

## Verification
Some rules are checked by the assertions on every cycle. A locked write must leave the pipeline field unchanged. A switch write must set the mode to its data bit. An accept write with the host source off must give no pulse. A clear in test mode must leave every field at zero. A read of a foreign address must get no answer. Only the bench's scenarios can show the rest. These are the bit placement of each packed field on readback, the status word layout, the zero answer for unmapped indices, and the full mode sequences: locking, unlocking, clearing, and accept writes issued in operation mode.

// File: rtl/fe_ctrl_pkg.sv
package fe_ctrl_pkg;
  localparam int IDX_W = 22;

  localparam logic [IDX_W-1:0] IX_STATUS  = 22'h00;
  localparam logic [IDX_W-1:0] IX_MASK_LO = 22'h01;
  localparam logic [IDX_W-1:0] IX_PIPE    = 22'h03;
  localparam logic [IDX_W-1:0] IX_ACCEPT  = 22'h07;
  localparam logic [IDX_W-1:0] IX_DELAY   = 22'h08;
  localparam logic [IDX_W-1:0] IX_SRC     = 22'h0B;
  localparam logic [IDX_W-1:0] IX_FLAVOR  = 22'h0C;
  localparam logic [IDX_W-1:0] IX_TDATA   = 22'h0D;
  localparam logic [IDX_W-1:0] IX_TEST    = 22'h0F;
  localparam logic [IDX_W-1:0] IX_CLEAR   = 22'h11;

  // Status word: tag on top, five mode flags at the bottom.
  function automatic logic [31:0] f_status(input logic [23:0] tag, input logic src,
                                           input logic flv, input logic tm,
                                           input logic td, input logic id);
    return {tag, 3'b000, src, flv, tm, td, id};
  endfunction

  // Two fields packed into one word: low field at bit 0, high field at bit HI_POS.
  function automatic logic [31:0] f_pack(input logic [15:0] lo, input logic [15:0] hi,
                                         input int hi_pos);
    logic [31:0] w;
    w = 32'(lo) | (32'(hi) << hi_pos);
    return w;
  endfunction
endpackage

// File: rtl/fe_ctrl_addr_dec.sv
module fe_ctrl_addr_dec
  import fe_ctrl_pkg::*;
(
  input  logic [4:0]       geo_addr,
  input  logic [31:0]      bus_addr,
  output logic             addr_hit,
  output logic [IDX_W-1:0] addr_idx
);
  assign addr_hit = (bus_addr[31:27] == geo_addr) && (bus_addr[26:24] == 3'b000)
                    && (bus_addr[1:0] == 2'b00);
  assign addr_idx = bus_addr[23:2];
endmodule

// File: rtl/fe_ctrl_store.sv
module fe_ctrl_store
  import fe_ctrl_pkg::*;
#(
  parameter int          MASK_W   = 48,
  parameter int          PIPE_W   = 9,
  parameter int          LEN_W    = 6,
  parameter int          DLY_W    = 8,
  parameter int          OFS_W    = 8,
  parameter logic [23:0] PROG_TAG = 24'hC0FFEE,
  parameter bit          CHIP_ID  = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              addr_hit,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [MASK_W-1:0] wire_mask,
  output logic [PIPE_W-1:0] pipe_size,
  output logic [LEN_W-1:0]  buf_len,
  output logic [DLY_W-1:0]  clk_delay,
  output logic [OFS_W-1:0]  bunch_offset,
  output logic              test_mode,
  output logic              test_data_mode,
  output logic              flavor_new,
  output logic              accept_src_host,
  output logic              accept_pulse,
  output logic [1:0]        accept_code
);
  localparam int HALF    = MASK_W / 2;
  localparam int LEN_POS = 16;
  localparam int OFS_POS = 8;

  // Named internal events
  logic wr_hit, wr_open, clr_go, acc_wr, rd_hit;
  assign wr_hit  = bus_wr && addr_hit;
  assign wr_open = wr_hit && test_mode;
  assign clr_go  = wr_open && (addr_idx == IX_CLEAR);
  assign acc_wr  = wr_hit && (addr_idx == IX_ACCEPT);
  assign rd_hit  = bus_rd && addr_hit;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // Mask halves, one register per index
  for (genvar h = 0; h < 2; h++) begin : g_mask
    logic [HALF-1:0] half_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr_go) half_q <= '0;
      else if (wr_open && addr_idx == (IX_MASK_LO + IDX_W'(h))) half_q <= bus_wdata[HALF-1:0];
    end
    assign wire_mask[h*HALF +: HALF] = half_q;
  end

  // Packed configuration fields and mode bits
  always_ff @(posedge clk) begin
    if (!rst_n || clr_go) begin
      pipe_size       <= '0;
      buf_len         <= '0;
      clk_delay       <= '0;
      bunch_offset    <= '0;
      accept_src_host <= 1'b0;
      flavor_new      <= 1'b0;
      test_data_mode  <= 1'b0;
    end else if (wr_open) begin
      if (addr_idx == IX_PIPE) begin
        pipe_size <= bus_wdata[PIPE_W-1:0];
        buf_len   <= bus_wdata[LEN_POS +: LEN_W];
      end
      if (addr_idx == IX_DELAY) begin
        clk_delay    <= bus_wdata[DLY_W-1:0];
        bunch_offset <= bus_wdata[OFS_POS +: OFS_W];
      end
      if (addr_idx == IX_SRC)    accept_src_host <= bus_wdata[0];
      if (addr_idx == IX_FLAVOR) flavor_new      <= bus_wdata[0];
      if (addr_idx == IX_TDATA)  test_data_mode  <= bus_wdata[0];
    end
  end

  // Mode switch: writable in every mode
  always_ff @(posedge clk) begin
    if (!rst_n) test_mode <= 1'b0;
    else if (wr_hit && addr_idx == IX_TEST) test_mode <= bus_wdata[0];
  end

  // Accept trigger: writable in every mode, pulses only with host source
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_pulse <= 1'b0;
      accept_code  <= 2'b00;
    end else begin
      accept_pulse <= acc_wr && accept_src_host;
      if (acc_wr && accept_src_host) accept_code <= bus_wdata[1:0];
    end
  end

  // Read mux
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr_idx)
      IX_STATUS:      rd_mux = f_status(PROG_TAG, accept_src_host, flavor_new, test_mode,
                                        test_data_mode, CHIP_ID);
      IX_MASK_LO:     rd_mux = 32'(wire_mask[HALF-1:0]);
      IX_MASK_LO + 1: rd_mux = 32'(wire_mask[MASK_W-1:HALF]);
      IX_PIPE:        rd_mux = f_pack(16'(pipe_size), 16'(buf_len), LEN_POS);
      IX_DELAY:       rd_mux = f_pack(16'(clk_delay), 16'(bunch_offset), OFS_POS);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_hit;
      rd_data  <= rd_hit ? rd_mux : '0;
    end
  end

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !test_mode && addr_idx == IX_PIPE) |=> $stable(pipe_size)); // R3
  AST_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && addr_idx == IX_TEST) |=> (test_mode == $past(bus_wdata[0]))); // R2
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !accept_src_host) |=> !accept_pulse); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> (wire_mask == '0 && pipe_size == '0 && buf_len == '0 && clk_delay == '0
                && bunch_offset == '0 && test_mode)); // R5
  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_hit) |=> (!rd_valid && rd_data == '0)); // R1
endmodule

// File: rtl/fe_ctrl_regs.sv
module fe_ctrl_regs
  import fe_ctrl_pkg::*;
#(
  parameter int          MASK_W   = 48,
  parameter int          PIPE_W   = 9,
  parameter int          LEN_W    = 6,
  parameter int          DLY_W    = 8,
  parameter int          OFS_W    = 8,
  parameter logic [23:0] PROG_TAG = 24'hC0FFEE,
  parameter bit          CHIP_ID  = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        geo_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [MASK_W-1:0] wire_mask,
  output logic [PIPE_W-1:0] pipe_size,
  output logic [LEN_W-1:0]  buf_len,
  output logic [DLY_W-1:0]  clk_delay,
  output logic [OFS_W-1:0]  bunch_offset,
  output logic              test_mode,
  output logic              test_data_mode,
  output logic              flavor_new,
  output logic              accept_src_host,
  output logic              accept_pulse,
  output logic [1:0]        accept_code
);
  logic             addr_hit;
  logic [IDX_W-1:0] addr_idx;

  fe_ctrl_addr_dec u_dec (
    .geo_addr (geo_addr),
    .bus_addr (bus_addr),
    .addr_hit (addr_hit),
    .addr_idx (addr_idx)
  );

  fe_ctrl_store #(
    .MASK_W(MASK_W), .PIPE_W(PIPE_W), .LEN_W(LEN_W), .DLY_W(DLY_W),
    .OFS_W(OFS_W), .PROG_TAG(PROG_TAG), .CHIP_ID(CHIP_ID)
  ) u_store (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .addr_hit        (addr_hit),
    .addr_idx        (addr_idx),
    .bus_wdata       (bus_wdata),
    .rd_data         (rd_data),
    .rd_valid        (rd_valid),
    .wire_mask       (wire_mask),
    .pipe_size       (pipe_size),
    .buf_len         (buf_len),
    .clk_delay       (clk_delay),
    .bunch_offset    (bunch_offset),
    .test_mode       (test_mode),
    .test_data_mode  (test_data_mode),
    .flavor_new      (flavor_new),
    .accept_src_host (accept_src_host),
    .accept_pulse    (accept_pulse),
    .accept_code     (accept_code)
  );
endmodule

// File: tb/fe_ctrl_regs_tb.sv
module fe_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  geo_addr = 5'd9;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [47:0] wire_mask;
  logic [8:0]  pipe_size;
  logic [5:0]  buf_len;
  logic [7:0]  clk_delay, bunch_offset;
  logic        test_mode, test_data_mode, flavor_new, accept_src_host, accept_pulse;
  logic [1:0]  accept_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] TAG_WORD = 32'hC0FFEE00;

  always #2.5 clk = ~clk;

  fe_ctrl_regs #(.PROG_TAG(24'hC0FFEE), .CHIP_ID(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .geo_addr(geo_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .wire_mask(wire_mask), .pipe_size(pipe_size), .buf_len(buf_len),
    .clk_delay(clk_delay), .bunch_offset(bunch_offset), .test_mode(test_mode),
    .test_data_mode(test_data_mode), .flavor_new(flavor_new),
    .accept_src_host(accept_src_host), .accept_pulse(accept_pulse),
    .accept_code(accept_code)
  );

  function automatic logic [31:0] mk(input logic [4:0] g, input logic [21:0] ix);
    return {g, 3'b000, ix, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_raw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr(input logic [21:0] ix, input logic [31:0] d);
    wr_raw(mk(geo_addr, ix), d);
  endtask

  task automatic rd_raw(input logic [31:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic rd_chk(input string req, input logic [21:0] ix, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    rd_raw(mk(geo_addr, ix), d, v);
    chk(req, {31'd0, v, d}, {31'd0, 1'b1, exp});
  endtask

  task automatic t_reset;
    chk("R2 reset op mode", 64'(test_mode), 64'd0);
    chk("R8 reset mask", 64'(wire_mask), 64'd0);
    rd_chk("R6 status after reset", 22'h00, TAG_WORD | 32'h01);
  endtask

  task automatic t_foreign;
    logic [31:0] d;
    logic v;
    wr_raw(mk(5'd3, 22'h0F), 32'h1);
    chk("R1 wrong slot write", 64'(test_mode), 64'd0);
    wr_raw(mk(geo_addr, 22'h0F) | 32'h1, 32'h1);
    chk("R1 low bits set write", 64'(test_mode), 64'd0);
    wr_raw(mk(geo_addr, 22'h0F) | 32'h0200_0000, 32'h1);
    chk("R1 reserved bits set write", 64'(test_mode), 64'd0);
    rd_raw(mk(5'd3, 22'h00), d, v);
    chk("R1 wrong slot read", {31'd0, v, d}, 64'd0);
  endtask

  task automatic t_locked;
    wr(22'h01, 32'h00AB_CDEF);
    wr(22'h03, 32'h0015_0011);
    rd_chk("R3 mask locked", 22'h01, 32'h0);
    rd_chk("R3 pipe locked", 22'h03, 32'h0);
  endtask

  task automatic t_open;
    wr(22'h0F, 32'h1);
    chk("R2 enter test mode", 64'(test_mode), 64'd1);
    wr(22'h01, 32'hFF12_3456);
    wr(22'h02, 32'h00AB_CDEF);
    rd_chk("R8 mask low", 22'h01, 32'h0012_3456);
    rd_chk("R8 mask high", 22'h02, 32'h00AB_CDEF);
    chk("R8 mask port", 64'(wire_mask), 64'hABCDEF_123456);
    wr(22'h03, 32'hFFFF_FFFF);
    rd_chk("R7 pipe and length", 22'h03, 32'h003F_01FF);
    wr(22'h03, 32'h0015_0102);
    chk("R7 pipe port", 64'({pipe_size, buf_len}), 64'({9'h102, 6'h15}));
    wr(22'h08, 32'hFFFF_FFFF);
    rd_chk("R9 delay and offset", 22'h08, 32'h0000_FFFF);
    wr(22'h08, 32'h0000_5A3C);
    chk("R9 ports", 64'({clk_delay, bunch_offset}), 64'(16'h3C5A));
  endtask

  task automatic t_modes;
    wr(22'h0B, 32'h1);
    wr(22'h0C, 32'h1);
    wr(22'h0D, 32'h1);
    rd_chk("R11 R6 status all modes", 22'h00, TAG_WORD | 32'h1F);
    chk("R11 mode ports", 64'({accept_src_host, flavor_new, test_data_mode}), 64'd7);
    rd_chk("R10 write-only mode index reads zero", 22'h0C, 32'h0);
  endtask

  task automatic t_accept;
    wr(22'h07, 32'h2);
    chk("R4 pulse in test mode", 64'({accept_pulse, accept_code}), 64'({1'b1, 2'd2}));
    @(negedge clk);
    chk("R4 pulse one cycle", 64'(accept_pulse), 64'd0);
    rd_chk("R10 accept index reads zero", 22'h07, 32'h0);
    wr(22'h0F, 32'h0);
    chk("R2 leave test mode", 64'(test_mode), 64'd0);
    wr(22'h07, 32'h1);
    chk("R4 pulse in op mode", 64'({accept_pulse, accept_code}), 64'({1'b1, 2'd1}));
    wr(22'h0F, 32'h1);
    wr(22'h0B, 32'h0);
    wr(22'h0F, 32'h0);
    wr(22'h07, 32'h3);
    chk("R4 no pulse, host source off", 64'({accept_pulse, accept_code}), 64'({1'b0, 2'd1}));
  endtask

  task automatic t_clear;
    wr(22'h11, 32'h0);
    chk("R5 clear ignored in op mode", 64'(wire_mask), 64'hABCDEF_123456);
    wr(22'h0F, 32'h1);
    wr(22'h11, 32'h0);
    chk("R5 mask cleared", 64'(wire_mask), 64'd0);
    rd_chk("R5 pipe cleared", 22'h03, 32'h0);
    rd_chk("R5 delay cleared", 22'h08, 32'h0);
    rd_chk("R5 status keeps test mode", 22'h00, TAG_WORD | 32'h05);
  endtask

  task automatic t_unmapped;
    rd_chk("R10 unmapped index", 22'h20, 32'h0);
    rd_chk("R10 clear index", 22'h11, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_foreign();
    t_locked();
    t_open();
    t_modes();
    t_accept();
    t_clear();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule